// File: doc/BRIEF.md
# Multi-Mode Timer Channel Controller

This block is a single timer channel whose behaviour is chosen by a 7-bit mode field held in a control register. The channel contains the following pieces:

- a 16-bit free-running counter;
- two double-buffered data registers, A and B, each with a compare (staging) copy and a capture (active) copy;
- a two-stage input synchroniser with edge detection;
- an output flip-flop that drives a pin.

The mode decoder recognises three kinds of behaviour. In the parking (GPIO) kind, the counter, the flag and the capture and compare logic are all held idle. In single-action input capture, a selected input edge stores the counter value. In single-action output compare, a counter match drives the pin to a chosen level.

Software reaches the channel through a plain register port. A write is accepted in every cycle in which `reg_wr` is high. Reads are combinational from `reg_addr` and carry no side effects. There is no back-pressure, and there is no streaming data path.

A mode change is expected to pass through a parking mode. Inside a parking mode, a write to a data register fills both of its copies, which prepares the channel for the next mode. On entry into output compare, the pin is preset to the inverse of the polarity bit.

Top module: `tmr_chan_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, the counter reads 0, and `pin_out` is 0. The register addresses are: 0 control, 1 A capture copy, 2 B capture copy, 3 status, 4 counter, 5 A compare copy, 6 B compare copy.
- R2: The control register fields are mode in [6:0], polarity in [7] and software output level in [8], and they read back as written. Mode 7'h02 selects input capture and mode 7'h43 selects output compare. Every other mode value is a parking mode, which is an output parking mode when mode bit 6 is 1 and an input parking mode otherwise.
- R3: In a parking mode, the counter is cleared and stays at 0.
- R4: Outside a parking mode, the counter increases by one on every clock and wraps from 16'hFFFF to 0.
- R5: In a parking mode, a write to A (address 1) or B (address 2) stores the value into both the compare copy and the capture copy of that register.
- R6: Outside a parking mode, a data write updates only the compare copy, and the capture copy read at address 1 or 2 keeps its value.
- R7: In a parking mode, the flag (status bit 0) is forced to 0.
- R8: Writing a 1 to status bit 0 clears the flag on the next clock, provided no new event occurs in the same cycle.
- R9: On the first clock in output-compare mode, `pin_out` becomes the inverse of the polarity bit.
- R10: In output compare, when the counter equals the A compare copy, the next clock drives `pin_out` to the polarity level and sets the flag.
- R11: In input capture, a synchronised edge that matches the polarity (1 = rising, 0 = falling) copies the counter into the A capture copy and sets the flag. An edge of the opposite direction is ignored.
- R12: In the output parking mode, `pin_out` follows the software output level one clock after it is written. Status bit 1 always shows the synchronised `pin_in`, and status bit 2 shows `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register address for both reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| pin_in | input | 1 | Asynchronous input pin |
| pin_out | output | 1 | Channel output pin |

## Verification
The hardest situation to reach is an input capture whose stored counter value must be predicted exactly. The capture value depends on three register stages between the pin and the capture copy, and on the counter restarting from 0 when the channel leaves a parking mode.

The stimulus works from a known origin. It writes the capture mode at a known edge, counts edges from that point, and changes `pin_in` at a chosen negative edge. The expected capture value is the edge count plus two. A wrong-direction edge is sent first, so that a capture which fires on either edge shows up as a corrupted A value.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    MK_PARK_IN  = 2'd0,
    MK_PARK_OUT = 2'd1,
    MK_CAPTURE  = 2'd2,
    MK_COMPARE  = 2'd3
  } mode_kind_e;

  localparam int MODE_W = 7;
  localparam logic [MODE_W-1:0] MODE_CAPTURE = 7'h02;
  localparam logic [MODE_W-1:0] MODE_COMPARE = 7'h43;
  localparam int DIR_BIT = MODE_W - 1;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_A_ACT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_B_ACT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_A_STG  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_B_STG  = 3'd6;

  localparam int POL_BIT   = 7;
  localparam int SWOUT_BIT = 8;

endpackage

// File: rtl/tmr_mode_decode.sv
module tmr_mode_decode
  import tmr_chan_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output mode_kind_e        kind,
  output logic              is_park
);

  always_comb begin
    if (mode == MODE_CAPTURE)      kind = MK_CAPTURE;
    else if (mode == MODE_COMPARE) kind = MK_COMPARE;
    else if (mode[DIR_BIT])        kind = MK_PARK_OUT;
    else                           kind = MK_PARK_IN;
  end

  assign is_park = (kind == MK_PARK_IN) || (kind == MK_PARK_OUT);

endmodule

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + ONE;
  end

  // R3: parking holds the counter at zero
  p_park_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

  // R4: running counter steps by one, wrapping naturally
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt == CNT_W'($past(cnt) + ONE)));

endmodule

// File: rtl/tmr_dual_buf.sv
module tmr_dual_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         park,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         cap,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] stage,
  output logic [W-1:0] act
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      act   <= '0;
    end else if (park) begin
      if (wr) begin
        stage <= wdata;
        act   <= wdata;
      end
    end else begin
      if (wr)  stage <= wdata;
      if (cap) act   <= cap_val;
    end
  end

  // R5: a parking-mode write lands in both copies
  p_park_dual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (park && wr) |=> (act == stage) && (act == $past(wdata)));

  // R6: outside parking, a write leaves the capture copy alone
  p_stage_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!park && wr && !cap) |=> $stable(act));

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[LAST-1:0], din};
      prev  <= chain[LAST];
    end
  end

  assign level = chain[LAST];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [CNT_W-1:0]      reg_wdata,
  output logic [CNT_W-1:0]      reg_rdata,
  input  logic                  pin_in,
  output logic                  pin_out
);

  localparam int NBUF = 2;
  localparam int CTRL_USED = SWOUT_BIT + 1;

  logic [MODE_W-1:0] mode_q;
  logic              pol_q;
  logic              swout_q;
  mode_kind_e        kind, prev_kind;
  logic              is_park;
  logic [CNT_W-1:0]  cnt;
  logic              lvl, rise, fall;
  logic              flag_q, out_q;
  logic              entry, match, capt, set_evt, clr_req;
  logic [CNT_W-1:0]  stg [NBUF];
  logic [CNT_W-1:0]  act [NBUF];

  tmr_mode_decode u_dec (
    .mode    (mode_q),
    .kind    (kind),
    .is_park (is_park)
  );

  tmr_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (is_park),
    .cnt   (cnt)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    localparam logic [ADDR_W-1:0] WADR = (i == 0) ? ADR_A_ACT : ADR_B_ACT;
    logic cap_i;
    assign cap_i = (i == 0) ? capt : 1'b0;
    tmr_dual_buf #(.W(CNT_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .park    (is_park),
      .wr      (reg_wr && (reg_addr == WADR)),
      .wdata   (reg_wdata),
      .cap     (cap_i),
      .cap_val (cnt),
      .stage   (stg[i]),
      .act     (act[i])
    );
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      pol_q   <= 1'b0;
      swout_q <= 1'b0;
    end else if (reg_wr && reg_addr == ADR_CTRL) begin
      mode_q  <= reg_wdata[MODE_W-1:0];
      pol_q   <= reg_wdata[POL_BIT];
      swout_q <= reg_wdata[SWOUT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_kind <= MK_PARK_IN;
    else        prev_kind <= kind;
  end

  assign entry   = (kind == MK_COMPARE) && (prev_kind != MK_COMPARE);
  assign match   = (kind == MK_COMPARE) && !entry && (cnt == stg[0]);
  assign capt    = (kind == MK_CAPTURE) && (pol_q ? rise : fall);
  assign set_evt = match || capt;
  assign clr_req = reg_wr && (reg_addr == ADR_STATUS) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (is_park) flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else begin
      case (kind)
        MK_PARK_OUT: out_q <= swout_q;
        MK_COMPARE: begin
          if (entry)      out_q <= ~pol_q;
          else if (match) out_q <= pol_q;
        end
        default: ;
      endcase
    end
  end

  assign pin_out = out_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:   reg_rdata[CTRL_USED-1:0] = {swout_q, pol_q, mode_q};
      ADR_A_ACT:  reg_rdata = act[0];
      ADR_B_ACT:  reg_rdata = act[1];
      ADR_STATUS: reg_rdata[2:0] = {out_q, lvl, flag_q};
      ADR_COUNT:  reg_rdata = cnt;
      ADR_A_STG:  reg_rdata = stg[0];
      ADR_B_STG:  reg_rdata = stg[1];
      default:    reg_rdata = '0;
    endcase
  end

  // R7: parking forces the flag low
  p_flag_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_park |=> !flag_q);

  // R8: write-one-to-clear without a competing event
  p_flag_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag_q);

  // R9: compare entry presets the pin to the inverse polarity
  p_oc_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (pin_out == !$past(pol_q)));

  // R10: compare match drives polarity level and raises the flag
  p_oc_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (pin_out == $past(pol_q)) && flag_q);

  // R11: a qualifying edge stores the counter and raises the flag
  p_ic_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    capt |=> flag_q && (act[0] == $past(cnt)));

  // R12: output parking mode mirrors the software level
  p_park_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MK_PARK_OUT) |=> (pin_out == $past(swout_q)));

endmodule

// File: tb/test_tmr_chan_ctrl.sv
module test_tmr_chan_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_in = 1'b0;
  logic        pin_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_chan_ctrl i_tmr_chan_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out)
  );

  task automatic chk(input logic [15:0] actual, input logic [15:0] expected, input string what);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, actual, expected);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk(v, 16'h0, $sformatf("R1 reset read addr %0d", a));
    end
    chk({15'h0, pin_out}, 16'h0, "R1 reset pin_out");
  endtask

  task automatic t_park();
    logic [15:0] v;
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h1234);
    wr(3'd2, 16'h00AB);
    rd(3'd1, v); chk(v, 16'h1234, "R5 A capture copy");
    rd(3'd5, v); chk(v, 16'h1234, "R5 A compare copy");
    rd(3'd2, v); chk(v, 16'h00AB, "R5 B capture copy");
    rd(3'd6, v); chk(v, 16'h00AB, "R5 B compare copy");
    step(5);
    rd(3'd4, v); chk(v, 16'h0, "R3 counter held in parking");
    pin_in = 1'b1; step(3);
    rd(3'd3, v); chk(v & 16'h2, 16'h2, "R12 synced input high");
    pin_in = 1'b0; step(3);
    rd(3'd3, v); chk(v & 16'h2, 16'h0, "R12 synced input low");
    wr(3'd0, 16'h0140);
    rd(3'd0, v); chk(v, 16'h0140, "R2 control readback");
    step(1); chk({15'h0, pin_out}, 16'h1, "R12 pin follows sw level 1");
    wr(3'd0, 16'h0040);
    step(1); chk({15'h0, pin_out}, 16'h0, "R12 pin follows sw level 0");
  endtask

  task automatic t_bad_mode();
    logic [15:0] v;
    wr(3'd0, 16'h0155);
    step(6);
    rd(3'd4, v); chk(v, 16'h0, "R2 mode 55 parks counter");
    chk({15'h0, pin_out}, 16'h1, "R2 mode 55 acts as output parking");
    wr(3'd0, 16'h0003);
    step(6);
    rd(3'd4, v); chk(v, 16'h0, "R2 mode 03 parks counter");
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_oc(input logic pol, input logic [15:0] cmp);
    logic [15:0] v;
    wr(3'd0, 16'h0040 | (16'(pol) << 8));
    wr(3'd1, cmp);
    chk({15'h0, pin_out}, {15'h0, pol}, "R12 pre-compare pin level");
    wr(3'd0, 16'h0043 | (16'(pol) << 7));
    step(1);
    chk({15'h0, pin_out}, {15'h0, ~pol}, "R9 entry presets inverse");
    step(int'(cmp) - 1);
    chk({15'h0, pin_out}, {15'h0, ~pol}, "R10 no early match");
    rd(3'd3, v); chk(v & 16'h1, 16'h0, "R10 flag low before match");
    step(1);
    chk({15'h0, pin_out}, {15'h0, pol}, "R10 match drives polarity");
    rd(3'd3, v); chk(v & 16'h1, 16'h1, "R10 flag set on match");
    rd(3'd4, v); chk(v, cmp + 16'd1, "R4 counter runs from zero");
    wr(3'd3, 16'h0001);
    rd(3'd3, v); chk(v & 16'h1, 16'h0, "R8 write one clears flag");
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_ic(input logic pol);
    logic [15:0] v;
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h1234);
    pin_in = pol; step(4);
    wr(3'd0, 16'h0002 | (16'(pol) << 7));
    step(2);
    pin_in = ~pol;
    step(5);
    rd(3'd3, v); chk(v & 16'h1, 16'h0, "R11 wrong edge sets no flag");
    rd(3'd1, v); chk(v, 16'h1234, "R11 wrong edge captures nothing");
    pin_in = pol;
    step(2);
    rd(3'd3, v); chk(v & 16'h1, 16'h0, "R11 flag not yet set");
    step(1);
    rd(3'd3, v); chk(v & 16'h1, 16'h1, "R11 flag set by edge");
    rd(3'd1, v); chk(v, 16'd9, "R11 captured counter value");
    wr(3'd1, 16'hBEEF);
    rd(3'd1, v); chk(v, 16'd9, "R6 capture copy unchanged");
    rd(3'd5, v); chk(v, 16'hBEEF, "R6 compare copy written");
    wr(3'd0, 16'h0000);
    step(1);
    rd(3'd3, v); chk(v & 16'h1, 16'h0, "R7 parking clears flag");
    rd(3'd4, v); chk(v, 16'h0, "R3 parking clears counter");
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(3'd0, 16'h0002);
    step(65535);
    rd(3'd4, v); chk(v, 16'hFFFF, "R4 counter at all ones");
    step(1);
    rd(3'd4, v); chk(v, 16'h0000, "R4 counter wraps to zero");
    wr(3'd0, 16'h0000);
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_park();
    t_bad_mode();
    t_oc(1'b0, 16'd5);
    t_oc(1'b1, 16'd12);
    t_ic(1'b1);
    t_ic(1'b0);
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule